// File: doc/BRIEF.md
# Procedure Call and Return Frame Sequencer

This block carries out the multi-cycle procedure entry and exit sequences of a stack processor that caches its top-of-stack value in a register. The execute unit raises `start` for one cycle (or longer) together with the operation type and the 24-bit instruction argument. It also presents the current program counter, frame pointer, stack pointer and cached top value. The sequencer copies these into its own working registers. It then drives the shared single-port memory one access per cycle and keeps `busy` high until the sequence is finished. In the last cycle it raises `done`, and the updated register values are on its outputs for the execute unit to take back.

On entry, the cached top is spilled to memory and the return address (PC+1) goes into the top register. The callee's first word gives the frame size k. The old frame pointer is linked at FP+k, FP and SP move to FP+k, the return address is saved just above the new frame base, and control continues at the target plus one. On exit, the block picks between a plain return and a value-returning return by itself. It does this by checking whether anything was pushed above the saved return address. In both cases it restores PC and FP from the frame.

States: `ST_IDLE`, then on a call `ST_C_PUSH` → `ST_C_SIZE` → `ST_C_LINK` → `ST_C_SAVE` → `ST_DONE`. On a return `ST_R_PC` → `ST_R_FP` → (`ST_R_POP` when there is no value, `ST_R_PUT` when there is one) → `ST_DONE`. From `ST_DONE` the block goes back to `ST_IDLE`. Only a `start` seen in `ST_IDLE` causes a transition out of it.

Top module: `frame_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_we` and `mem_re` are 0 and all four register outputs are 0.
- R2: A `start` sampled in idle makes `busy` go high on the next cycle. `busy` stays high for exactly 5 cycles for a call (`op_ret`=0) and 4 cycles for a return (`op_ret`=1). `done` is high only in the last of those cycles, and `busy` is low in the cycle after it.
- R3: A call first writes the incoming top value to M[SP+1].
- R4: A call then reads k = M[arg] (arg zero-extended to 32 bits) and writes the old FP to M[FP+k].
- R5: A call writes PC+1 to M[FP+k+1]. It finishes with FP = FP+k, SP = FP+k+1, TS = PC+1 and PC = arg+1.
- R6: A return sets PC = M[FP+1] and FP = M[FP], with both words read before the return writes anything to memory.
- R7: A return with SP = FP+1 (the frame base) has no value. It sets SP = FP−arg and TS = M[FP−arg], and writes no memory.
- R8: A return with SP ≠ FP+1 carries a value. It writes the incoming TS to M[FP−arg+1] and sets SP = FP−arg+1, and TS keeps its incoming value.
- R9: `start` held high or pulsed while `busy` is high is ignored. The running sequence keeps its length and its results.
- R10: In no cycle are `mem_we` and `mem_re` both high, and with `busy` low neither of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op_ret | input | 1 | 0 = call, 1 = return |
| arg | input | 24 | Call target or return frame-drop count |
| pc_in | input | 32 | Program counter at start |
| fp_in | input | 32 | Frame pointer at start |
| sp_in | input | 32 | Stack pointer at start |
| ts_in | input | 32 | Cached top of stack at start |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe for this cycle |
| mem_re | output | 1 | Memory read strobe for this cycle |
| mem_rdata | input | 32 | Read data, valid in the same cycle as `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| pc_out | output | 32 | Program counter result |
| fp_out | output | 32 | Frame pointer result |
| sp_out | output | 32 | Stack pointer result |
| ts_out | output | 32 | Top-of-stack result |

## Verification
The checks assume a memory that returns the addressed word combinationally in the cycle `mem_re` is high and takes writes at the clock edge. The stimulus has a bench memory model of exactly that kind. The register inputs only need to be valid in the cycle where `start` is taken. The bench drives them together with `start` and changes them only between sequences. Call targets and frames are placed so that the model's ordering of reads and writes decides every overlap. This includes a return with argument 1, whose result slot is the saved frame-pointer word. The same applies to a zero-size frame, whose link word falls on the frame base.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_PUSH,
        ST_C_SIZE,
        ST_C_LINK,
        ST_C_SAVE,
        ST_R_PC,
        ST_R_FP,
        ST_R_POP,
        ST_R_PUT,
        ST_DONE
    } fseq_state_e;

endpackage

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
    import frame_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_ret,
    input  logic        has_val,
    output fseq_state_e state,
    output logic        take,
    output logic        busy,
    output logic        done
);

    fseq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = op_ret ? ST_R_PC : ST_C_PUSH;
            ST_C_PUSH: state_nx = ST_C_SIZE;
            ST_C_SIZE: state_nx = ST_C_LINK;
            ST_C_LINK: state_nx = ST_C_SAVE;
            ST_C_SAVE: state_nx = ST_DONE;
            ST_R_PC:   state_nx = ST_R_FP;
            ST_R_FP:   state_nx = has_val ? ST_R_PUT : ST_R_POP;
            ST_R_POP:  state_nx = ST_DONE;
            ST_R_PUT:  state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        take = (state == ST_IDLE) && start;
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

endmodule

// File: rtl/frame_seq_regs.sv
module frame_seq_regs
    import frame_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fseq_state_e   state,
    input  logic          take,
    input  logic [AW-1:0] arg,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] fp_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] ts_in,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] pc_q,
    output logic [DW-1:0] fp_q,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] ts_q,
    output logic [DW-1:0] nx_q,
    output logic [DW-1:0] ff_q,
    output logic [DW-1:0] argx_q,
    output logic          has_val
);

    localparam int PADW = DW - AW;
    localparam logic [DW-1:0] ONE = DW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            fp_q    <= '0;
            sp_q    <= '0;
            ts_q    <= '0;
            nx_q    <= '0;
            ff_q    <= '0;
            argx_q  <= '0;
            has_val <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        pc_q   <= pc_in;
                        fp_q   <= fp_in;
                        sp_q   <= sp_in;
                        ts_q   <= ts_in;
                        argx_q <= {{PADW{1'b0}}, arg};
                    end
                end
                ST_C_PUSH: begin
                    sp_q <= sp_q + ONE;
                    ts_q <= pc_q + ONE;
                    nx_q <= argx_q;
                end
                ST_C_SIZE: ff_q <= rdata;
                ST_C_LINK: begin
                    fp_q <= fp_q + ff_q;
                    sp_q <= fp_q + ff_q;
                end
                ST_C_SAVE: begin
                    sp_q <= fp_q + ONE;
                    pc_q <= nx_q + ONE;
                end
                ST_R_PC: begin
                    pc_q    <= rdata;
                    has_val <= (sp_q != fp_q + ONE);
                end
                ST_R_FP: nx_q <= rdata;
                ST_R_POP: begin
                    sp_q <= fp_q - argx_q;
                    ts_q <= rdata;
                    fp_q <= nx_q;
                end
                ST_R_PUT: begin
                    sp_q <= fp_q - argx_q + ONE;
                    fp_q <= nx_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/frame_seq_agen.sv
module frame_seq_agen
    import frame_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  fseq_state_e   state,
    input  logic [DW-1:0] fp_q,
    input  logic [DW-1:0] sp_q,
    input  logic [DW-1:0] ts_q,
    input  logic [DW-1:0] nx_q,
    input  logic [DW-1:0] ff_q,
    input  logic [DW-1:0] argx_q,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        addr  = '0;
        wdata = '0;
        we    = 1'b0;
        re    = 1'b0;
        unique case (state)
            ST_C_PUSH: begin addr = sp_q + ONE;           wdata = ts_q; we = 1'b1; end
            ST_C_SIZE: begin addr = nx_q;                 re = 1'b1;               end
            ST_C_LINK: begin addr = fp_q + ff_q;          wdata = fp_q; we = 1'b1; end
            ST_C_SAVE: begin addr = fp_q + ONE;           wdata = ts_q; we = 1'b1; end
            ST_R_PC:   begin addr = fp_q + ONE;           re = 1'b1;               end
            ST_R_FP:   begin addr = fp_q;                 re = 1'b1;               end
            ST_R_POP:  begin addr = fp_q - argx_q;        re = 1'b1;               end
            ST_R_PUT:  begin addr = fp_q - argx_q + ONE;  wdata = ts_q; we = 1'b1; end
            ST_IDLE, ST_DONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_ret,
    input  logic [AW-1:0] arg,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] fp_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] ts_in,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] fp_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] ts_out
);

    fseq_state_e   state;
    logic          take;
    logic          has_val;
    logic [DW-1:0] nx_q, ff_q, argx_q;

    frame_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op_ret(op_ret),
        .has_val(has_val), .state(state), .take(take),
        .busy(busy), .done(done)
    );

    frame_seq_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .state(state), .take(take), .arg(arg),
        .pc_in(pc_in), .fp_in(fp_in), .sp_in(sp_in), .ts_in(ts_in),
        .rdata(mem_rdata),
        .pc_q(pc_out), .fp_q(fp_out), .sp_q(sp_out), .ts_q(ts_out),
        .nx_q(nx_q), .ff_q(ff_q), .argx_q(argx_q), .has_val(has_val)
    );

    frame_seq_agen #(.DW(DW)) u_agen (
        .state(state), .fp_q(fp_out), .sp_q(sp_out), .ts_q(ts_out),
        .nx_q(nx_q), .ff_q(ff_q), .argx_q(argx_q),
        .addr(mem_addr), .wdata(mem_wdata), .we(mem_we), .re(mem_re)
    );

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_we,
    input logic mem_re
);

    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("a_r2_start_raises_busy");

    a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy)
        else $error("a_r2_done_then_idle");

    a_r2_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("a_r2_done_inside_busy");

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy)
        else $error("a_r9_busy_holds");

    a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re))
        else $error("a_r10_one_access");

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re))
        else $error("a_r10_idle_quiet");

endmodule

bind frame_seq frame_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/frame_seq_test.sv
module frame_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_ret = 1'b0;
    logic [23:0] arg = '0;
    logic [31:0] pc_in = '0, fp_in = '0, sp_in = '0, ts_in = '0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, busy, done;
    logic [31:0] pc_out, fp_out, sp_out, ts_out;

    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    frame_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_ret(op_ret), .arg(arg),
        .pc_in(pc_in), .fp_in(fp_in), .sp_in(sp_in), .ts_in(ts_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .pc_out(pc_out), .fp_out(fp_out), .sp_out(sp_out), .ts_out(ts_out)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: applies the sequence to ref_mem in the required order
    task automatic run_seq(input bit is_ret, input logic [23:0] a,
                           input logic [31:0] p, input logic [31:0] f,
                           input logic [31:0] s, input logic [31:0] t,
                           input bit hold, input string req);
        logic [31:0] ep, ef, es, et, k, ax, oldfp;
        int n;
        ax = {8'h0, a};
        if (!is_ret) begin
            ref_mem[8'(s + 1)] = t;                 // R3
            k = ref_mem[ax[7:0]];                   // R4
            ref_mem[8'(f + k)] = f;
            ref_mem[8'(f + k + 1)] = p + 1;         // R5
            ep = ax + 1; ef = f + k; es = f + k + 1; et = p + 1;
            n = 5;
        end else begin
            ep = ref_mem[8'(f + 1)];                // R6
            oldfp = ref_mem[f[7:0]];
            if (s == f + 1) begin                   // R7
                es = f - ax;
                et = ref_mem[8'(f - ax)];
            end else begin                          // R8
                ref_mem[8'(f - ax + 1)] = t;
                es = f - ax + 1;
                et = t;
            end
            ef = oldfp;
            n = 4;
        end
        @(negedge clk);
        op_ret = is_ret; arg = a; pc_in = p; fp_in = f; sp_in = s; ts_in = t;
        start = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            chk({req, " R2 busy"}, {31'b0, busy}, 32'd1);
            chk({req, " R2 done"}, {31'b0, done}, {31'b0, i == n});
            chk({req, " R10 access"}, {31'b0, mem_we & mem_re}, 32'd0);
            if (!hold || i == n) start = 1'b0;
        end
        @(negedge clk);
        chk({req, " R2 idle"}, {31'b0, busy}, 32'd0);
        chk({req, " pc"}, pc_out, ep);
        chk({req, " fp"}, fp_out, ef);
        chk({req, " sp"}, sp_out, es);
        chk({req, " ts"}, ts_out, et);
        for (int j = 0; j < 256; j++)
            if (mem[j] !== ref_mem[j]) chk({req, " memory"}, mem[j], ref_mem[j]);
        checks = checks + 1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 32'h1000 + 32'(i);
            ref_mem[i] = 32'h1000 + 32'(i);
        end
        mem[100] = 32'd5;  ref_mem[100] = 32'd5;
        mem[150] = 32'd0;  ref_mem[150] = 32'd0;
        mem[200] = 32'd3;  ref_mem[200] = 32'd3;
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 strobes", {30'b0, mem_we, mem_re}, 32'd0);
        chk("R1 regs", pc_out | fp_out | sp_out | ts_out, 32'd0);
        rst_n = 1'b1;

        // R3 R4 R5: call with k=5
        run_seq(1'b0, 24'd100, 32'd10, 32'd20, 32'd22, 32'h55, 1'b0, "R5 call");
        // R7 R6: plain return back out of that frame
        run_seq(1'b1, 24'd2, pc_out, fp_out, sp_out, ts_out, 1'b0, "R7 plain");
        chk("R6 restored fp", fp_out, 32'd20);
        chk("R6 restored pc", pc_out, 32'd11);
        // call again, then a value pushed by the body: R8
        run_seq(1'b0, 24'd100, 32'd40, 32'd20, 32'd22, 32'h66, 1'b0, "R5 call2");
        run_seq(1'b1, 24'd2, pc_out, fp_out, sp_out + 1, 32'h77, 1'b0, "R8 value");
        chk("R8 result word", mem[24], 32'h77);
        // R9: start held through a call with zero frame size
        run_seq(1'b0, 24'd150, 32'd60, 32'd30, 32'd33, 32'h99, 1'b1, "R9 hold");
        // R8 corner: arg=1 puts the result on the saved-FP word after it is read
        run_seq(1'b0, 24'd200, 32'd70, 32'd50, 32'd52, 32'h12, 1'b0, "R4 call3");
        run_seq(1'b1, 24'd1, pc_out, fp_out, sp_out + 2, 32'hAB, 1'b1, "R8 arg1");
        chk("R6 arg1 fp", fp_out, 32'd50);
        // R7 corner: arg=0 plain return
        run_seq(1'b0, 24'd200, 32'd80, 32'd60, 32'd61, 32'h34, 1'b0, "R3 call4");
        run_seq(1'b1, 24'd0, pc_out, fp_out, sp_out, ts_out, 1'b0, "R7 arg0");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule